// File: doc/BRIEF.md
# Multi-target mailbox send unit

This block is the transmit half of an inter-processor mailbox. A local processor stages a 64-bit message through a small register window. The message is written as a low word and a high word, and then a target number from 0 to 7 is written. A trigger write then hands the message to one of eight remote cores. Each target has its own message slot. The slot is presented on a per-target valid line and held until the remote side pulses that target's fetch line.

For every target the block keeps three flags: busy, overflow and delivered. They are packed into one status word. Delivered and overflow flags are cleared by writing ones to a clear register. A delivery or an overflow that is not masked sets a sticky interrupt-pending bit, which drives the interrupt output until software clears it.

Top module: `mbox_send_unit`

## Requirements
- R1: After reset the status word at 0x14 reads 0, the interrupt register at 0x18 reads 0, the mask register at 0x1C reads 0x7, `irqOut` is low and no `remValid` bit is set.
- R2: Writes to 0x0 (target number, bits [2:0]), 0x4 (low word) and 0x8 (high word) are held and read back unchanged at the same offsets.
- R3: A write to 0xC with bit 0 set, while the staged target T is not busy, does three things from the next cycle on. It sets busy bit T (status bit T) and raises `remValid[T]`. It also presents {high word, low word} on lane T of `remMsg` (bits 64*T+63 down to 64*T). A write to 0xC with bit 0 clear changes nothing.
- R4: A `remFetch[T]` pulse while target T is busy clears busy bit T and sets delivered bit T (status bit 16+T) in the next cycle.
- R5: A trigger while target T is already busy sets overflow bit T (status bit 8+T) and discards the new message: lane T keeps its old contents and busy stays set.
- R6: A write to 0x10 clears every delivered bit (data bits [23:16]) and every overflow bit (data bits [15:8]) that is written as 1. It leaves all other flags and all busy bits unchanged.
- R7: The pending bit (0x18 bit 0) sets in the cycle after an accepted fetch when mask bit 2 is 0, or in the cycle after an overflow trigger when mask bit 1 is 0. When the matching mask bit is 1, the event leaves it unchanged.
- R8: Writing 0x18 with bit 0 set clears the pending bit, and writing it with bit 0 clear does not. `irqOut` always equals the pending bit.
- R9: The mask register at 0x1C holds data bits [2:0] (bit 0 block event, bit 1 overflow, bit 2 delivery; 1 disables) and reads them back.
- R10: A `remFetch[T]` pulse while target T is not busy has no effect on any flag or on the pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Register byte offset |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, same cycle |
| remValid | output | 8 | Per-target message pending toward the remote core |
| remMsg | output | 512 | Per-target 64-bit message lanes |
| remFetch | input | 8 | Per-target fetch pulse from the remote core |
| irqOut | output | 1 | Interrupt request, level |

## Verification
The embedded properties take for granted that the reset is held low through the first clock edge. They also assume that every bus write lasts exactly one cycle, so a trigger strobe is never repeated by a held write enable. The properties make no assumption about `remFetch`: a pulse on an idle target is legal and must leave every flag alone. The stimulus drives all inputs on the falling edge and issues one bus operation per cycle. It never clears a flag in the same cycle an event sets it, so the bench's arithmetic model does not have to decide collisions that the design resolves with set-wins priority.

// File: rtl/mbox_send_pkg.sv
package mbox_send_pkg;

  localparam int OFS_ID   = 'h00;
  localparam int OFS_LO   = 'h04;
  localparam int OFS_HI   = 'h08;
  localparam int OFS_TRIG = 'h0C;
  localparam int OFS_CLR  = 'h10;
  localparam int OFS_STAT = 'h14;
  localparam int OFS_IRQ  = 'h18;
  localparam int OFS_MASK = 'h1C;

  // field positions inside the status word
  localparam int FLD_BUSY = 0;
  localparam int FLD_OVF  = 8;
  localparam int FLD_DEL  = 16;

  // mask bit positions
  localparam int MSK_BLK = 0;
  localparam int MSK_OVF = 1;
  localparam int MSK_DEL = 2;

  typedef struct packed {
    logic wrId;
    logic wrLo;
    logic wrHi;
    logic trig;
    logic clrFlags;
    logic clrIrq;
    logic wrMask;
  } mbxStrobe_t;

endpackage

// File: rtl/mbox_send_ctl.sv
module mbox_send_ctl
  import mbox_send_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busBit0,
  output mbxStrobe_t        str
);

  always_comb begin
    str = '0;
    if (busWe) begin
      if (busAddr == ADDR_W'(OFS_ID))   str.wrId     = 1'b1;
      if (busAddr == ADDR_W'(OFS_LO))   str.wrLo     = 1'b1;
      if (busAddr == ADDR_W'(OFS_HI))   str.wrHi     = 1'b1;
      if (busAddr == ADDR_W'(OFS_TRIG)) str.trig     = busBit0;
      if (busAddr == ADDR_W'(OFS_CLR))  str.clrFlags = 1'b1;
      if (busAddr == ADDR_W'(OFS_IRQ))  str.clrIrq   = busBit0;
      if (busAddr == ADDR_W'(OFS_MASK)) str.wrMask   = 1'b1;
    end
  end

endmodule

// File: rtl/mbox_send_dp.sv
module mbox_send_dp
  import mbox_send_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  mbxStrobe_t                str,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [WORD_W-1:0]         busWdata,
  output logic [WORD_W-1:0]         busRdata,
  input  logic [NUM_TGT-1:0]        remFetch,
  output logic [NUM_TGT-1:0]        remValid,
  output logic [NUM_TGT*2*WORD_W-1:0] remMsg,
  output logic                      irqOut
);

  localparam int ID_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;
  localparam int MSG_W = 2 * WORD_W;

  logic [ID_W-1:0]    idQ;
  logic [WORD_W-1:0]  loQ, hiQ;
  logic [2:0]         maskQ;
  logic [NUM_TGT-1:0] busyQ, ovfQ, delQ;
  logic               irqPendQ;
  logic [MSG_W-1:0]   slotQ [NUM_TGT];

  logic               busyHit;
  logic               ovfEvt;
  logic [NUM_TGT-1:0] accVec, takeVec, ovfVec, clrDel, clrOvf;
  logic [WORD_W-1:0]  statWord;

  always_comb begin
    busyHit = busyQ[idQ];
    accVec  = remFetch & busyQ;
    ovfEvt  = str.trig && busyHit;
    takeVec = (str.trig && !busyHit) ? (NUM_TGT'(1) << idQ) : '0;
    ovfVec  = ovfEvt ? (NUM_TGT'(1) << idQ) : '0;
    clrDel  = str.clrFlags ? busWdata[FLD_DEL +: NUM_TGT] : '0;
    clrOvf  = str.clrFlags ? busWdata[FLD_OVF +: NUM_TGT] : '0;
  end

  // staging and mask registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idQ   <= '0;
      loQ   <= '0;
      hiQ   <= '0;
      maskQ <= 3'b111;
    end else begin
      if (str.wrId)   idQ   <= busWdata[ID_W-1:0];
      if (str.wrLo)   loQ   <= busWdata;
      if (str.wrHi)   hiQ   <= busWdata;
      if (str.wrMask) maskQ <= busWdata[2:0];
    end
  end

  // per-target flags; a setting event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= '0;
      ovfQ     <= '0;
      delQ     <= '0;
      irqPendQ <= 1'b0;
    end else begin
      busyQ    <= (busyQ & ~accVec) | takeVec;
      delQ     <= (delQ & ~clrDel) | accVec;
      ovfQ     <= (ovfQ & ~clrOvf) | ovfVec;
      irqPendQ <= (irqPendQ & ~str.clrIrq)
                | ((|accVec) & ~maskQ[MSK_DEL])
                | (ovfEvt & ~maskQ[MSK_OVF]);
    end
  end

  // one message slot per target
  for (genvar g = 0; g < NUM_TGT; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)           slotQ[g] <= '0;
      else if (takeVec[g]) slotQ[g] <= {hiQ, loQ};
    end
    assign remMsg[g*MSG_W +: MSG_W] = slotQ[g];
  end

  assign remValid = busyQ;
  assign irqOut   = irqPendQ;

  always_comb begin
    statWord = '0;
    statWord[FLD_BUSY +: NUM_TGT] = busyQ;
    statWord[FLD_OVF  +: NUM_TGT] = ovfQ;
    statWord[FLD_DEL  +: NUM_TGT] = delQ;
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(OFS_ID))   busRdata = WORD_W'(idQ);
    if (busAddr == ADDR_W'(OFS_LO))   busRdata = loQ;
    if (busAddr == ADDR_W'(OFS_HI))   busRdata = hiQ;
    if (busAddr == ADDR_W'(OFS_STAT)) busRdata = statWord;
    if (busAddr == ADDR_W'(OFS_IRQ))  busRdata = WORD_W'(irqPendQ);
    if (busAddr == ADDR_W'(OFS_MASK)) busRdata = WORD_W'(maskQ);
  end

  // a fetched busy target leaves busy and shows delivered (R4)
  assert_fetch_delivers_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|(busyQ & remFetch)) |=>
      (((delQ & $past(busyQ & remFetch)) == $past(busyQ & remFetch)) &&
       ((busyQ & $past(busyQ & remFetch)) == '0)));

  // trigger on a busy target flags overflow and keeps it busy (R5)
  assert_overflow_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (str.trig && busyQ[idQ]) |=> (ovfQ[$past(idQ)] && busyQ[$past(idQ)]));

  // busy bits rise only through a trigger (R3)
  assert_busy_only_by_trig_R3: assert property (@(posedge clk) disable iff (!rstN)
    !str.trig |=> ((busyQ & ~$past(busyQ)) == '0));

  // pending bit rises only after a fetch or a trigger (R7)
  assert_irq_needs_event_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!irqPendQ && ((busyQ & remFetch) == '0) && !str.trig) |=> !irqPendQ);

  // mask register takes the written value (R9)
  assert_mask_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    str.wrMask |=> (maskQ == $past(busWdata[2:0])));

endmodule

// File: rtl/mbox_send_unit.sv
module mbox_send_unit
  import mbox_send_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busWe,
  input  logic [WORD_W-1:0]           busWdata,
  output logic [WORD_W-1:0]           busRdata,
  output logic [NUM_TGT-1:0]          remValid,
  output logic [NUM_TGT*2*WORD_W-1:0] remMsg,
  input  logic [NUM_TGT-1:0]          remFetch,
  output logic                        irqOut
);

  mbxStrobe_t str;

  mbox_send_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .busWe   (busWe),
    .busAddr (busAddr),
    .busBit0 (busWdata[0]),
    .str     (str)
  );

  mbox_send_dp #(.NUM_TGT(NUM_TGT), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .str      (str),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .remFetch (remFetch),
    .remValid (remValid),
    .remMsg   (remMsg),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/mbox_send_unit_tb.sv
`timescale 1ns/1ps
module mbox_send_unit_tb;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [4:0]   busAddr = '0;
  logic         busWe = 1'b0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic [7:0]   remValid;
  logic [511:0] remMsg;
  logic [7:0]   remFetch = '0;
  logic         irqOut;

  always #2 clk = ~clk;

  mbox_send_unit u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .remValid(remValid),
    .remMsg(remMsg), .remFetch(remFetch), .irqOut(irqOut)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model
  logic [7:0]  mBusy = '0, mOvf = '0, mDel = '0;
  logic        mPend = 1'b0;
  logic [2:0]  mMask = 3'b111;
  logic [63:0] mSlot [8];
  logic [31:0] sLo = '0, sHi = '0;
  logic [2:0]  sId = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    case (a)
      5'h00: sId = d[2:0];
      5'h04: sLo = d;
      5'h08: sHi = d;
      5'h0C: if (d[0]) begin
               if (mBusy[sId]) begin
                 mOvf[sId] = 1'b1;
                 if (!mMask[1]) mPend = 1'b1;
               end else begin
                 mBusy[sId] = 1'b1;
                 mSlot[sId] = {sHi, sLo};
               end
             end
      5'h10: begin mDel &= ~d[23:16]; mOvf &= ~d[15:8]; end
      5'h18: if (d[0]) mPend = 1'b0;
      5'h1C: mMask = d[2:0];
      default: ;
    endcase
  endtask

  task automatic fetch(input logic [7:0] v);
    logic [7:0] acc;
    @(negedge clk);
    remFetch = v;
    @(negedge clk);
    remFetch = '0;
    acc = v & mBusy;
    mBusy &= ~acc;
    mDel |= acc;
    if (acc != 0 && !mMask[2]) mPend = 1'b1;
  endtask

  task automatic checkAll(input string req);
    logic [31:0] d;
    rd(5'h14, d);
    chk({req, " status"}, {32'h0, d}, {40'h0, mDel, mOvf, mBusy});
    rd(5'h18, d);
    chk({req, " irqreg"}, {32'h0, d}, {63'h0, mPend});
    chk({req, " irqOut"}, {63'h0, irqOut}, {63'h0, mPend});
    chk({req, " remValid"}, {56'h0, remValid}, {56'h0, mBusy});
    for (int t = 0; t < 8; t++)
      chk({req, " lane"}, remMsg[t*64 +: 64], mSlot[t]);
  endtask

  initial begin
    logic [31:0] d;
    for (int t = 0; t < 8; t++) mSlot[t] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkAll("R1");
    rd(5'h1C, d);
    chk("R1 mask", {32'h0, d}, 64'h7);

    // R2 staging readback
    wr(5'h00, 32'h5);  wr(5'h04, 32'hCAFE0123); wr(5'h08, 32'h89ABF00D);
    rd(5'h00, d); chk("R2 id", {32'h0, d}, 64'h5);
    rd(5'h04, d); chk("R2 lo", {32'h0, d}, 64'hCAFE0123);
    rd(5'h08, d); chk("R2 hi", {32'h0, d}, 64'h89ABF00D);

    // R9 mask sweep
    for (int m = 0; m < 8; m++) begin
      wr(5'h1C, 32'(m));
      rd(5'h1C, d);
      chk("R9 mask", {32'h0, d}, 64'(m));
    end

    // main sweep over the two event masks and every target
    for (int m = 0; m < 4; m++) begin
      wr(5'h1C, {29'h0, m[1], m[0], 1'b1});
      for (int t = 0; t < 8; t++) begin
        wr(5'h04, 32'h1000_0000 * (m + 1) + 32'(t * 17));
        wr(5'h08, ~(32'h0101_0101 * (t + 1)) ^ 32'(m));
        wr(5'h00, 32'(t));
        wr(5'h0C, 32'h1);
        checkAll("R3 accept");
        wr(5'h00, 32'((t + 1) % 8));
        wr(5'h0C, 32'h2);
        checkAll("R3 ignored");
        wr(5'h00, 32'(t));
        wr(5'h04, 32'hDEAD_0000 | 32'(t));
        wr(5'h0C, 32'h1);
        checkAll("R5 R7 overflow");
        fetch(8'(1 << t) | 8'(1 << ((t + 3) % 8)));
        checkAll("R4 R10 R7 fetch");
        fetch(8'(1 << t));
        checkAll("R10 idle fetch");
        wr(5'h10, {8'h0, 8'h00, 8'(1 << t), 8'hFF});
        checkAll("R6 clear ovf");
        wr(5'h18, 32'h0);
        checkAll("R8 no clear");
        wr(5'h18, 32'h1);
        checkAll("R8 clear");
      end
      // all targets busy, one common fetch
      for (int t = 0; t < 8; t++) begin
        wr(5'h00, 32'(t));
        wr(5'h04, 32'(t * 3 + m));
        wr(5'h0C, 32'h1);
      end
      checkAll("R3 all busy");
      fetch(8'hA5);
      checkAll("R4 partial");
      fetch(8'hFF);
      checkAll("R4 rest");
      wr(5'h10, 32'h00F0_0F00);
      checkAll("R6 partial clear");
      wr(5'h10, 32'h00FF_FF00);
      wr(5'h18, 32'h1);
      checkAll("R6 R8 full clear");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule